// File: doc/BRIEF.md
# Gated Trace Port Clock Generator

This block makes the clock that times a debug trace port's data and frame-marker pins, derived from the system clock. A 2-bit ratio input selects the system clock itself or one half, one quarter or one eighth of it. Alongside the clock it produces a one-cycle enable strobe for logic that stays in the system clock domain, and a gating-control output.

A gate-enable bit, zero after reset, decides whether the clock may be stopped. When the bit is set and the port is enabled with nothing to transmit (transmit-busy low), the block parks the clock low and raises the gating-control output. A new ratio, a start or stop of gating, and a port enable or disable are all applied only at a divided-period boundary, so the output never carries a shortened phase.

Control is a three-state machine. The states are OFF (port disabled, clock held low), RUN (clock toggling) and PARKED (gating active, clock held low). Its transitions are WAKE_RUN (OFF to RUN: port enabled and gating not wanted), WAKE_PARK (OFF to PARKED: port enabled and gating wanted), PARK (RUN to PARKED: gate bit set and transmit-busy low), UNPARK (PARKED to RUN: gate bit cleared or transmit-busy high), and SHUT_RUN and SHUT_PARK (RUN or PARKED to OFF: port disabled). Every transition is taken only on a period-boundary cycle.

Top module: `trace_clk_gen`

## Requirements
- R1: The ratio input encodes the divisor as 2'b00 = 1, 2'b01 = 2, 2'b10 = 4, 2'b11 = 8. In steady running the output clock has exactly one rising edge per N system clock cycles.
- R2: For N of 2, 4 or 8 the output clock is high for N/2 consecutive system cycles and low for N/2. For N = 1 it is high during each system clock high phase and low during each low phase.
- R3: The enable strobe is high for one system cycle, in exactly the cycles in which the output clock rose, and at no other time.
- R4: A ratio change takes effect only at the end of the current divided period. Every high pulse around the change has the full length of either the old or the new ratio, and afterwards the new ratio holds.
- R5: With the gate bit at 0 and the port enabled, the clock runs freely whatever the transmit-busy input is, and the gating-control output stays low.
- R6: With the gate bit at 1, the port enabled and transmit-busy low, the output clock stays low, the strobe stays low and the gating-control output is high.
- R7: When transmit-busy rises while parked, the first rising edge of the output clock appears within N+1 system cycles, and gating-control falls.
- R8: With the port disabled, the output clock, the strobe and the gating-control output stay low whatever the gate bit and transmit-busy are.
- R9: During reset the output clock, the strobe and the gating-control output are low. The ratio input is taken up on the first cycle after reset.
- R10: Parking, unparking, shut-down and wake-up happen only at a period boundary while the divided clock is low, so every high pulse has its full length even when the controls toggle at random times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 2 | Divide ratio select |
| gate_en | input | 1 | Gating enable configuration bit |
| port_en | input | 1 | Trace port enabled |
| tx_busy | input | 1 | Trace port has a message in transmission |
| clk_out | output | 1 | Divided and gated trace clock |
| clk_en | output | 1 | One-cycle strobe on each rising edge of clk_out |
| gate_ctl | output | 1 | High while the clock is held off by gating |

## Verification
The hardest case to reach from the ports is a ratio change or a gating toggle that lands in the middle of a divided period, because only then would a design that applied the change at once produce a shortened pulse. The bench waits for a rising edge of the output clock and then changes the ratio after each offset from 0 to 7 system cycles, for all sixteen old and new ratio pairs. A monitor samples the output in both halves of every system cycle and measures each high pulse. A second pass toggles the port-enable and transmit-busy inputs at irregular intervals under every ratio, with the same pulse-length monitor running.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_PARKED = 2'd2
    } tcg_state_e;

endpackage

// File: rtl/tcg_ratio_ctl.sv
// Holds the active divide ratio and the phase counter; flags the last
// cycle of each divided period, where a new ratio may be taken up.
module tcg_ratio_ctl #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic [SEL_W-1:0] k_q,
    output logic [SEL_W-1:0] k_nxt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             bnd
);
    localparam int LIM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [LIM_W-1:0] last_ph;

    always_comb begin
        last_ph = (LIM_W'(1) << k_q) - LIM_W'(1);
        bnd     = ({1'b0, cnt_q} == last_ph);
        k_nxt   = bnd ? div_sel : k_q;
        cnt_nxt = bnd ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q   <= '0;
            cnt_q <= '0;
        end else begin
            k_q   <= k_nxt;
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/tcg_gate_fsm.sv
// Three-state control: OFF, RUN, PARKED. Moves only on boundary cycles.
module tcg_gate_fsm
    import tcg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bnd,
    input  logic       port_en,
    input  logic       gate_en,
    input  logic       tx_busy,
    output tcg_state_e st_q,
    output tcg_state_e st_nxt,
    output logic       gate_ctl
);
    logic want_park;

    always_comb begin
        want_park = gate_en && !tx_busy;
        st_nxt    = st_q;
        if (bnd) begin
            unique case (st_q)
                ST_OFF: begin
                    // WAKE_RUN / WAKE_PARK
                    if (port_en) st_nxt = want_park ? ST_PARKED : ST_RUN;
                end
                ST_RUN: begin
                    // SHUT_RUN / PARK
                    if (!port_en)      st_nxt = ST_OFF;
                    else if (want_park) st_nxt = ST_PARKED;
                end
                ST_PARKED: begin
                    // SHUT_PARK / UNPARK
                    if (!port_en)       st_nxt = ST_OFF;
                    else if (!want_park) st_nxt = ST_RUN;
                end
                default: st_nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_nxt;
    end

    always_comb begin
        gate_ctl = (st_q == ST_PARKED);
    end

endmodule

// File: rtl/tcg_wave_out.sv
// Forms the output waveform. Ratios above one come from a register;
// ratio one gates the system clock through a low-transparent latch.
module tcg_wave_out
    import tcg_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tcg_state_e       st_nxt,
    input  logic [SEL_W-1:0] k_nxt,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             lvl_q,
    output logic             clk_out,
    output logic             clk_en
);
    localparam int LIM_W = CNT_W + 1;

    logic             run_nxt;
    logic [LIM_W-1:0] half_nxt;
    logic             en_q;
    logic             fast_run;
    logic             fast_run_d;
    logic             fast_sel;
    logic             fast_lat;

    always_comb begin
        run_nxt  = (st_nxt == ST_RUN);
        half_nxt = (LIM_W'(1) << k_nxt) >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q      <= 1'b0;
            en_q       <= 1'b0;
            fast_run   <= 1'b0;
            fast_run_d <= 1'b0;
            fast_sel   <= 1'b0;
        end else begin
            lvl_q      <= run_nxt && (k_nxt != '0) && ({1'b0, cnt_nxt} < half_nxt);
            en_q       <= run_nxt && (cnt_nxt == '0);
            fast_run   <= run_nxt && (k_nxt == '0);
            fast_run_d <= fast_run;
            fast_sel   <= (k_nxt == '0);
        end
    end

    always_latch begin
        if (!clk) fast_lat = fast_run;
    end

    always_comb begin
        clk_out = fast_sel ? (clk & fast_lat) : lvl_q;
        clk_en  = fast_sel ? fast_run_d : en_q;
    end

endmodule

// File: rtl/trace_clk_gen.sv
module trace_clk_gen
    import tcg_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             gate_en,
    input  logic             port_en,
    input  logic             tx_busy,
    output logic             clk_out,
    output logic             clk_en,
    output logic             gate_ctl
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [SEL_W-1:0] k_q;
    logic [SEL_W-1:0] k_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             bnd;
    tcg_state_e       st_q;
    tcg_state_e       st_nxt;
    logic             lvl_q;

    tcg_ratio_ctl #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_ratio (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .k_q     (k_q),
        .k_nxt   (k_nxt),
        .cnt_nxt (cnt_nxt),
        .bnd     (bnd)
    );

    tcg_gate_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bnd      (bnd),
        .port_en  (port_en),
        .gate_en  (gate_en),
        .tx_busy  (tx_busy),
        .st_q     (st_q),
        .st_nxt   (st_nxt),
        .gate_ctl (gate_ctl)
    );

    tcg_wave_out #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_nxt  (st_nxt),
        .k_nxt   (k_nxt),
        .cnt_nxt (cnt_nxt),
        .lvl_q   (lvl_q),
        .clk_out (clk_out),
        .clk_en  (clk_en)
    );

endmodule

// File: rtl/tcg_chk.sv
module tcg_chk
    import tcg_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic             gate_en,
    input logic             tx_busy,
    input logic             clk_en,
    input logic             gate_ctl,
    input logic             lvl_q,
    input logic             bnd,
    input logic [SEL_W-1:0] k_q,
    input tcg_state_e       st_q
);

    // R6
    parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_ctl && $past(gate_ctl)) |-> !clk_en);

    // R3
    rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_q) |-> clk_en);

    // R4
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(k_q) |-> $past(bnd));

    // R10
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q) |-> $past(bnd && !lvl_q));

    // R8
    wake_needs_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_OFF && $past(st_q == ST_OFF)) |-> $past(port_en));

    // R6
    park_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PARKED && $past(st_q != ST_PARKED)) |-> $past(gate_en && !tx_busy));

endmodule

bind trace_clk_gen tcg_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .gate_en  (gate_en),
    .tx_busy  (tx_busy),
    .clk_en   (clk_en),
    .gate_ctl (gate_ctl),
    .lvl_q    (lvl_q),
    .bnd      (bnd),
    .k_q      (k_q),
    .st_q     (st_q)
);

// File: tb/trace_clk_gen_tb.sv
`timescale 1ns/1ps
module trace_clk_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       gate_en = 1'b0;
    logic       port_en = 1'b0;
    logic       tx_busy = 1'b0;
    logic       clk_out;
    logic       clk_en;
    logic       gate_ctl;

    int total = 0;
    int bad   = 0;

    // monitor state
    logic prev_s  = 1'b0;
    int   run_len = 0;
    int   runt_bad = 0;
    int   align_bad = 0;
    int   win_hi = 0, win_lo = 0, win_rise = 0, win_en = 0, win_len_bad = 0, win_gc = 0;
    int   exp_n = 1;
    int   tr_a = 1, tr_b = 1, tr_bad = 0;
    logic saw_rise = 1'b0;

    always #10 clk = ~clk;

    trace_clk_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .gate_en  (gate_en),
        .port_en  (port_en),
        .tx_busy  (tx_busy),
        .clk_out  (clk_out),
        .clk_en   (clk_en),
        .gate_ctl (gate_ctl)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic end_run(input int len);
        if (len != 1 && len != 2 && len != 4 && len != 8) runt_bad++;
        if (len != exp_n) win_len_bad++;
        if (len != tr_a && len != tr_b) tr_bad++;
    endtask

    task automatic take(input logic s, input bit high_half);
        if (s && !prev_s) begin
            run_len = 1;
            if (high_half) begin
                win_rise++;
                saw_rise = 1'b1;
            end
        end else if (s) begin
            run_len++;
        end else if (prev_s) begin
            end_run(run_len);
        end
        prev_s = s;
    endtask

    // one system cycle: sample in the high half, then in the low half
    task automatic step();
        logic exp_en;
        @(posedge clk);
        #5;
        exp_en = clk_out && !prev_s;
        if (clk_en !== exp_en) align_bad++;
        if (clk_out) win_hi++;
        if (clk_en) win_en++;
        if (gate_ctl) win_gc++;
        take(clk_out, 1'b1);
        @(negedge clk);
        #5;
        if (clk_out) win_lo++;
        take(clk_out, 1'b0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_win();
        win_hi = 0; win_lo = 0; win_rise = 0; win_en = 0; win_len_bad = 0; win_gc = 0;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #5;
        check(clk_out === 1'b0, "R9 clk_out in reset", int'(clk_out), 0);
        check(clk_en === 1'b0, "R9 clk_en in reset", int'(clk_en), 0);
        check(gate_ctl === 1'b0, "R9 gate_ctl in reset", int'(gate_ctl), 0);
        @(negedge clk);
        #5;
        div_sel = 2'd2;
        port_en = 1'b1;
        rst_n   = 1'b1;
        steps(20);
        clear_win();
        exp_n = 4;
        steps(32);
        check(win_rise == 8, "R9 ratio taken after reset", win_rise, 8);

        // R1 R2 R3 R5 R6 R8: steady sweep over every configuration
        for (int d = 0; d < 4; d++) begin
            for (int cfg = 0; cfg < 8; cfg++) begin
                int n;
                bit run, park;
                n = 1 << d;
                div_sel = 2'(d);
                port_en = cfg[0];
                gate_en = cfg[1];
                tx_busy = cfg[2];
                run  = cfg[0] && !(cfg[1] && !cfg[2]);
                park = cfg[0] && cfg[1] && !cfg[2];
                steps(20);
                clear_win();
                exp_n = n;
                steps(32);
                if (run) begin
                    check(win_rise == 32 / n, "R1 rising edges per window", win_rise, 32 / n);
                    check(win_hi == (n == 1 ? 32 : 16), "R2 high-half samples", win_hi, n == 1 ? 32 : 16);
                    check(win_lo == (n == 1 ? 0 : 16), "R2 low-half samples", win_lo, n == 1 ? 0 : 16);
                    check(win_len_bad == 0, "R2 pulse length", win_len_bad, 0);
                    check(win_en == 32 / n, "R3 strobe count", win_en, 32 / n);
                end else begin
                    check(win_hi + win_lo == 0, park ? "R6 parked clock low" : "R8 disabled clock low",
                          win_hi + win_lo, 0);
                    check(win_en == 0, park ? "R6 parked strobe low" : "R8 disabled strobe low", win_en, 0);
                end
                if (!cfg[1] && cfg[0])
                    check(win_gc == 0, "R5 gating control low", win_gc, 0);
                else
                    check(win_gc == (park ? 32 : 0), park ? "R6 gating control high" : "R8 gating control",
                          win_gc, park ? 32 : 0);
            end
        end

        // R4: ratio change at every offset after a rising edge, all pairs
        gate_en = 1'b0; tx_busy = 1'b0; port_en = 1'b1;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int off = 0; off < 8; off++) begin
                    int guard;
                    div_sel = 2'(a);
                    exp_n = 1 << a;
                    tr_a = 1 << a; tr_b = 1 << a;
                    steps(20);
                    saw_rise = 1'b0;
                    guard = 0;
                    while (!saw_rise && guard < 20) begin
                        step();
                        guard++;
                    end
                    steps(off);
                    tr_a = 1 << a; tr_b = 1 << b;
                    tr_bad = 0;
                    div_sel = 2'(b);
                    steps(20);
                    check(tr_bad == 0, "R4 no shortened pulse on ratio change", tr_bad, 0);
                    clear_win();
                    exp_n = 1 << b;
                    steps(16);
                    check(win_rise == 16 / (1 << b), "R4 new ratio in force", win_rise, 16 / (1 << b));
                end
            end
        end

        // R7: unpark delay
        for (int d = 0; d < 4; d++) begin
            int n, wait_c;
            n = 1 << d;
            div_sel = 2'(d);
            port_en = 1'b1; gate_en = 1'b1; tx_busy = 1'b0;
            steps(20);
            check(gate_ctl === 1'b1, "R7 parked before release", int'(gate_ctl), 1);
            tx_busy = 1'b1;
            saw_rise = 1'b0;
            wait_c = 0;
            while (!saw_rise && wait_c < 20) begin
                step();
                wait_c++;
            end
            check(wait_c >= 1 && wait_c <= n + 1, "R7 first edge after busy", wait_c, n + 1);
            check(gate_ctl === 1'b0, "R7 gating control cleared", int'(gate_ctl), 0);
        end

        // R10: irregular control toggling under each ratio
        for (int d = 0; d < 4; d++) begin
            div_sel = 2'(d);
            gate_en = 1'b1;
            tr_a = 1 << d; tr_b = 1 << d;
            steps(10);
            tr_bad = 0;
            for (int i = 0; i < 40; i++) begin
                tx_busy = ((i * 7) % 5) < 3;
                port_en = (i % 11) != 4;
                steps(1 + (i % 4));
            end
            port_en = 1'b1; tx_busy = 1'b1;
            steps(20);
            check(tr_bad == 0, "R10 full pulses across control toggles", tr_bad, 0);
        end

        check(runt_bad == 0, "R10 no runt pulse over whole run", runt_bad, 0);
        check(align_bad == 0, "R3 strobe aligned with every rise", align_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule